// File: doc/BRIEF.md
# Programmable Polyphase Interpolation Upsampler

This block raises the sample rate of a 16-bit signed transmit stream in two steps. A first stage inserts L1-1 implied zeros between input samples and filters the result with a programmable FIR. It does this in polyphase form: each accepted input sample yields L1 output phases. Each phase is a dot product of taps/L1 stored coefficients with the most recent input samples. One multiply-accumulate unit, shared by all taps and phases, works through these products one tap per clock. The wide sum is then rounded and saturated back to 16 bits. A second stage repeats every first-stage result on L2 consecutive strobes of an externally supplied rate enable.

The factors are set by small code fields in which an all-zero code selects the largest value. The tap count must divide evenly by L1. If it does not, the block flags the configuration and forces its output to zero until the fields are corrected. A bypass setting skips the first stage entirely, so each input sample goes straight to the repeating stage. Coefficients are loaded one per cycle through a write port.

Top module: `interp_upsampler`

## Requirements
- R1: After reset, out_data is 0, out_strobe is 0, cfg_err is 0 and in_ready is 1.
- R2: The code fields decode as follows: cfg_l1_code 0 gives L1 = 8, cfg_taps_code 0 gives 128 taps, cfg_l2_code 0 gives L2 = 32, and every other code gives its own binary value.
- R3: With bypass off, each accepted sample x[n] produces L1 first-stage results in phase order p = 0..L1-1. Each result is the sum over k = 0..taps/L1-1 of c[k*L1+p]*x[n-k], where samples before the first one after reset count as 0.
- R4: Each sum is reduced to 16 bits by adding 2^14 and shifting arithmetically right by 15. A result above 32767 gives 32767, and one below -32768 gives -32768.
- R5: Every first-stage result appears on out_data for exactly L2 consecutive out_strobe pulses, in order. out_strobe is high only in the cycle after a cycle in which rate_en was high.
- R6: When no result is waiting at the start of a repeat period, out_strobe stays low and out_data keeps its last value.
- R7: With bypass off and taps not a multiple of L1, cfg_err is high from the next cycle on. While it is high, in_ready is 0, out_data is 0 and out_strobe is 0. One cycle after the fields become legal, cfg_err falls and samples are accepted again.
- R8: With cfg_bypass at 1, each accepted sample reaches out_data unchanged as one first-stage result, and cfg_err stays 0 whatever the tap count.
- R9: A cycle with coef_we at 1 writes the signed Q1.15 value coef_data into coefficient c[coef_addr], for addresses 0 to 127.
- R10: A sample is taken only in a cycle with in_valid and in_ready both at 1. in_ready is 0 in the cycle after any accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_l1_code | input | 3 | First upsample factor code (0 means 8) |
| cfg_taps_code | input | 7 | Tap count code (0 means 128) |
| cfg_l2_code | input | 5 | Repeat factor code (0 means 32) |
| cfg_bypass | input | 1 | 1 routes samples past the first stage |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 7 | Coefficient index |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Block can take a sample this cycle |
| rate_en | input | 1 | Output-rate enable pulse |
| out_data | output | 16 | Signed output sample |
| out_strobe | output | 1 | out_data carries a sample this cycle |
| cfg_err | output | 1 | Tap count not a multiple of L1 |

## Verification
The hardest condition to reach from the ports is a saturated or half-LSB rounding result deep in the accumulator. Random coefficients and data seldom land exactly on a rounding tie or drive every tap to full scale. The stimulus therefore adds directed runs: one with every coefficient and sample at positive full scale, one at negative full scale, and one single-tap run whose inputs sit at ±16384 and one step beyond. The longest branch, a single phase of 128 taps, is reached by a run in which every coefficient address is loaded with a distinct random value, so a wrong index shows up in the output.

// File: rtl/interp_pkg.sv
package interp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_PUSH = 2'd2
  } mac_st_e;
endpackage

// File: rtl/interp_cfg.sv
// Decodes the code fields (zero selects the maximum), derives the branch
// length and checks that the tap count divides by the first factor.
module interp_cfg #(
  parameter int MAX_L1   = 8,
  parameter int MAX_TAPS = 128,
  parameter int MAX_L2   = 32,
  localparam int LW = $clog2(MAX_L1),
  localparam int TW = $clog2(MAX_TAPS),
  localparam int RW = $clog2(MAX_L2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] l1_code,
  input  logic [TW-1:0] taps_code,
  input  logic [RW-1:0] l2_code,
  input  logic          bypass_in,
  output logic [LW:0]   l1_q,
  output logic [TW:0]   blen_q,
  output logic [RW:0]   l2_q,
  output logic          byp_q,
  output logic          err_q
);
  logic [LW:0] l1_d;
  logic [TW:0] taps_d, l1_w, blen_d, rem_d;
  logic [RW:0] l2_d;
  logic        err_d;

  always_comb begin
    l1_d   = (l1_code == '0)   ? (LW+1)'(MAX_L1)   : {1'b0, l1_code};
    taps_d = (taps_code == '0) ? (TW+1)'(MAX_TAPS) : {1'b0, taps_code};
    l2_d   = (l2_code == '0)   ? (RW+1)'(MAX_L2)   : {1'b0, l2_code};
    l1_w   = (TW+1)'(l1_d);
    blen_d = taps_d / l1_w;
    rem_d  = taps_d % l1_w;
    err_d  = !bypass_in && (rem_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q   <= (LW+1)'(MAX_L1);
      blen_q <= (TW+1)'(MAX_TAPS / MAX_L1);
      l2_q   <= (RW+1)'(MAX_L2);
      byp_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      l1_q   <= l1_d;
      blen_q <= blen_d;
      l2_q   <= l2_d;
      byp_q  <= bypass_in;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/interp_mac.sv
// First stage: sample history, coefficient store, one shared MAC stepping
// through branches, rounding/saturation and a one-entry staging register.
module interp_mac
  import interp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int MAX_L1   = 8,
  parameter int MAX_TAPS = 128,
  localparam int LW = $clog2(MAX_L1),
  localparam int TW = $clog2(MAX_TAPS),
  localparam int AW = DW + CW + TW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LW:0]          l1,
  input  logic [TW:0]          blen,
  input  logic                 byp,
  input  logic                 err,
  input  logic                 coef_we,
  input  logic [TW-1:0]        coef_addr,
  input  logic signed [CW-1:0] coef_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  input  logic                 stg_ack,
  output logic                 stg_valid,
  output logic signed [DW-1:0] stg_data
);
  localparam logic signed [AW-1:0] SAT_HI = AW'(2**(DW-1) - 1);
  localparam logic signed [AW-1:0] SAT_LO = AW'(-(2**(DW-1)));
  localparam logic signed [AW-1:0] RND    = AW'(2**(CW-2));

  logic signed [DW-1:0] hist_q [MAX_TAPS];
  logic signed [CW-1:0] coef_q [MAX_TAPS];

  mac_st_e              st_q, st_d;
  logic [TW:0]          k_q, k_d, cidx_q, cidx_d, l1_w;
  logic [LW:0]          ph_q, ph_d, ph_inc;
  logic signed [AW-1:0] acc_q, acc_d, rnd, shv;
  logic signed [DW+CW-1:0] prod;
  logic signed [DW-1:0] sat_res, stg_data_d;
  logic                 stg_valid_d, accept, push;

  assign in_ready = !err && (st_q == ST_IDLE) && (byp ? !stg_valid : 1'b1);
  assign accept   = in_valid && in_ready;
  assign l1_w     = (TW+1)'(l1);
  assign ph_inc   = ph_q + (LW+1)'(1);
  assign prod     = hist_q[k_q[TW-1:0]] * coef_q[cidx_q[TW-1:0]];

  // Bit selection: round half up, then clamp to the output range.
  always_comb begin
    rnd = acc_q + RND;
    shv = rnd >>> (CW - 1);
    if (shv > SAT_HI)      sat_res = SAT_HI[DW-1:0];
    else if (shv < SAT_LO) sat_res = SAT_LO[DW-1:0];
    else                   sat_res = shv[DW-1:0];
  end

  // Sequencer next state.
  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    cidx_d = cidx_q;
    ph_d   = ph_q;
    acc_d  = acc_q;
    push   = 1'b0;
    if (err) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept && !byp) begin
            st_d   = ST_ACC;
            k_d    = '0;
            cidx_d = '0;
            ph_d   = '0;
            acc_d  = '0;
          end
        end
        ST_ACC: begin
          acc_d  = acc_q + {{TW{prod[DW+CW-1]}}, prod};
          k_d    = k_q + (TW+1)'(1);
          cidx_d = cidx_q + l1_w;
          if (k_q == blen - (TW+1)'(1)) st_d = ST_PUSH;
        end
        ST_PUSH: begin
          if (!stg_valid) begin
            push = 1'b1;
            if (ph_q == l1 - (LW+1)'(1)) begin
              st_d = ST_IDLE;
            end else begin
              st_d   = ST_ACC;
              ph_d   = ph_inc;
              cidx_d = (TW+1)'(ph_inc);
              k_d    = '0;
              acc_d  = '0;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Staging register next state.
  always_comb begin
    stg_valid_d = stg_valid;
    stg_data_d  = stg_data;
    if (err) begin
      stg_valid_d = 1'b0;
    end else begin
      if (stg_ack) stg_valid_d = 1'b0;
      if (push) begin
        stg_valid_d = 1'b1;
        stg_data_d  = sat_res;
      end else if (accept && byp) begin
        stg_valid_d = 1'b1;
        stg_data_d  = in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      k_q       <= '0;
      cidx_q    <= '0;
      ph_q      <= '0;
      acc_q     <= '0;
      stg_valid <= 1'b0;
      stg_data  <= '0;
    end else begin
      st_q      <= st_d;
      k_q       <= k_d;
      cidx_q    <= cidx_d;
      ph_q      <= ph_d;
      acc_q     <= acc_d;
      stg_valid <= stg_valid_d;
      stg_data  <= stg_data_d;
    end
  end

  // History shifts only when a filtered sample is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_TAPS; i++) hist_q[i] <= '0;
    end else if (accept && !byp) begin
      hist_q[0] <= in_data;
      for (int i = 1; i < MAX_TAPS; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_TAPS; i++) coef_q[i] <= '0;
    end else if (coef_we) begin
      coef_q[coef_addr] <= coef_data;
    end
  end

  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !byp) |=> !in_ready);

  assert_bypass_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && byp) |=> (stg_valid && stg_data == $past(in_data)));

  assert_stage_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && !stg_ack && !err) |=> (stg_valid && $stable(stg_data)));
endmodule

// File: rtl/interp_hold.sv
// Second stage: presents each staged result on L2 rate-enable strobes.
module interp_hold #(
  parameter int DW     = 16,
  parameter int MAX_L2 = 32,
  localparam int RW = $clog2(MAX_L2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RW:0]          l2,
  input  logic                 err,
  input  logic                 rate_en,
  input  logic                 stg_valid,
  input  logic signed [DW-1:0] stg_data,
  output logic                 stg_ack,
  output logic signed [DW-1:0] out_data,
  output logic                 out_strobe
);
  logic [RW:0]          rep_q, rep_d;
  logic signed [DW-1:0] data_d;
  logic                 strb_d;

  assign stg_ack = rate_en && !err && (rep_q == '0) && stg_valid;

  always_comb begin
    rep_d  = rep_q;
    data_d = out_data;
    strb_d = 1'b0;
    if (err) begin
      rep_d  = '0;
      data_d = '0;
    end else if (rate_en) begin
      if (rep_q != '0) begin
        rep_d  = rep_q - (RW+1)'(1);
        strb_d = 1'b1;
      end else if (stg_valid) begin
        rep_d  = l2 - (RW+1)'(1);
        data_d = stg_data;
        strb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q      <= '0;
      out_data   <= '0;
      out_strobe <= 1'b0;
    end else begin
      rep_q      <= rep_d;
      out_data   <= data_d;
      out_strobe <= strb_d;
    end
  end

  assert_strobe_follows_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> $past(rate_en));

  assert_quiet_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_strobe && !$past(err)) |-> $stable(out_data));

  assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!out_strobe && out_data == '0));
endmodule

// File: rtl/interp_upsampler.sv
module interp_upsampler #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int MAX_L1   = 8,
  parameter int MAX_TAPS = 128,
  parameter int MAX_L2   = 32,
  localparam int LW = $clog2(MAX_L1),
  localparam int TW = $clog2(MAX_TAPS),
  localparam int RW = $clog2(MAX_L2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LW-1:0]        cfg_l1_code,
  input  logic [TW-1:0]        cfg_taps_code,
  input  logic [RW-1:0]        cfg_l2_code,
  input  logic                 cfg_bypass,
  input  logic                 coef_we,
  input  logic [TW-1:0]        coef_addr,
  input  logic signed [CW-1:0] coef_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  input  logic                 rate_en,
  output logic signed [DW-1:0] out_data,
  output logic                 out_strobe,
  output logic                 cfg_err
);
  logic [LW:0]          l1;
  logic [TW:0]          blen;
  logic [RW:0]          l2;
  logic                 byp, stg_ack, stg_valid;
  logic signed [DW-1:0] stg_data;

  assign cfg_err = byp ? 1'b0 : err_int;
  logic err_int;

  interp_cfg #(.MAX_L1(MAX_L1), .MAX_TAPS(MAX_TAPS), .MAX_L2(MAX_L2)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .l1_code(cfg_l1_code), .taps_code(cfg_taps_code), .l2_code(cfg_l2_code),
    .bypass_in(cfg_bypass),
    .l1_q(l1), .blen_q(blen), .l2_q(l2), .byp_q(byp), .err_q(err_int)
  );

  interp_mac #(.DW(DW), .CW(CW), .MAX_L1(MAX_L1), .MAX_TAPS(MAX_TAPS)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .l1(l1), .blen(blen), .byp(byp), .err(err_int),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .stg_ack(stg_ack), .stg_valid(stg_valid), .stg_data(stg_data)
  );

  interp_hold #(.DW(DW), .MAX_L2(MAX_L2)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .l2(l2), .err(err_int), .rate_en(rate_en),
    .stg_valid(stg_valid), .stg_data(stg_data), .stg_ack(stg_ack),
    .out_data(out_data), .out_strobe(out_strobe)
  );
endmodule

// File: tb/interp_upsampler_tb.sv
`timescale 1ns/1ps
module interp_upsampler_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_l1_code;
  logic [6:0] cfg_taps_code;
  logic [4:0] cfg_l2_code;
  logic cfg_bypass, coef_we, in_valid, rate_en, in_ready, out_strobe, cfg_err;
  logic [6:0] coef_addr;
  logic signed [15:0] coef_data, in_data, out_data;

  interp_upsampler u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_l1_code(cfg_l1_code), .cfg_taps_code(cfg_taps_code),
    .cfg_l2_code(cfg_l2_code), .cfg_bypass(cfg_bypass),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rate_en(rate_en), .out_data(out_data), .out_strobe(out_strobe),
    .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic signed [15:0] coef_m [128];
  logic signed [15:0] xs [256];
  logic signed [15:0] exp_q [2048];
  logic signed [15:0] last_out;
  int exp_cnt, strobe_cnt, l1v, bv, l2v, rate_p, rcnt;
  bit rate_on = 0, mon_on = 0, byp_m, done = 0;
  string cur_tag = "R3";

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic signed [15:0] model(input int n, input int p);
    longint acc = 0;
    for (int k = 0; k < bv; k++)
      if (n - k >= 0) acc += longint'(coef_m[k*l1v+p]) * longint'(xs[n-k]);
    acc = (acc + 16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return 16'(acc);
  endfunction

  function automatic logic signed [15:0] sample(input int mode, input int i);
    logic signed [15:0] rl [6];
    rl = '{16'sd16384, 16'sd16383, -16'sd16384, -16'sd16385, 16'sd32767, -16'sd32768};
    case (mode)
      1: return 16'sd32767;
      2: return -16'sd32768;
      3: return rl[i % 6];
      default: return 16'($urandom_range(0, 65535));
    endcase
  endfunction

  // Rate-enable generator and output monitor in one process.
  initial begin
    rate_en = 0; rcnt = 0;
    forever begin
      @(negedge clk);
      if (mon_on && out_strobe) begin
        int idx;
        chk(rate_en == 1'b1, "R5", rate_en, 1);
        idx = strobe_cnt / l2v;
        if (idx < exp_cnt) chk(out_data == exp_q[idx], cur_tag, out_data, exp_q[idx]);
        else chk(1'b0, cur_tag, out_data, 0);
        strobe_cnt++;
        last_out = out_data;
      end
      if (rate_on) begin
        rcnt = (rcnt + 1 >= rate_p) ? 0 : rcnt + 1;
        rate_en = (rcnt == 0);
      end else begin
        rate_en = 0; rcnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", strobe_cnt, exp_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 0; in_valid = 0; coef_we = 0; coef_addr = 0; coef_data = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load_coefs(input int mode);
    for (int a = 0; a < 128; a++) begin
      case (mode)
        1: coef_m[a] = 16'sd32767;
        3: coef_m[a] = (a == 0) ? 16'sd1 : 16'sd0;
        default: coef_m[a] = 16'($urandom_range(0, 65535));
      endcase
      coef_we = 1; coef_addr = 7'(a); coef_data = coef_m[a];
      @(negedge clk);
    end
    coef_we = 0;
  endtask

  task automatic feed(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      in_data = sample(mode, i); in_valid = 1;
      while (!in_ready) @(negedge clk);
      xs[i] = in_data;
      if (byp_m) exp_q[exp_cnt++] = xs[i];
      else for (int p = 0; p < l1v; p++) exp_q[exp_cnt++] = model(i, p);
      @(negedge clk);
      if (!byp_m) chk(!in_ready, "R10", in_ready, 0);
    end
    in_valid = 0;
  endtask

  task automatic drain(input int target);
    int t = 0;
    while (strobe_cnt < target && t < 30000) begin @(negedge clk); t++; end
    chk(strobe_cnt == target, "R5", strobe_cnt, target);
    repeat (3 * rate_p) @(negedge clk);
    chk(strobe_cnt == target, "R6", strobe_cnt, target);
    chk(out_data == last_out, "R6", out_data, last_out);
    chk(!out_strobe, "R6", out_strobe, 0);
  endtask

  task automatic run(input string tag, input int l1c, input int tc, input int l2c,
                     input bit byp, input int n, input int cmode, input int dmode);
    int taps;
    cfg_l1_code = 3'(l1c); cfg_taps_code = 7'(tc); cfg_l2_code = 5'(l2c); cfg_bypass = byp;
    do_reset();
    chk(out_data == 0 && !out_strobe, "R1", out_data, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(cfg_err == 1'b0, byp ? "R8" : "R1", cfg_err, 0);
    l1v = (l1c == 0) ? 8 : l1c;
    taps = (tc == 0) ? 128 : tc;
    l2v = (l2c == 0) ? 32 : l2c;
    bv = taps / l1v;
    byp_m = byp;
    load_coefs(cmode);
    rate_p = byp ? 3 : bv + 3;
    exp_cnt = 0; strobe_cnt = 0; cur_tag = tag; mon_on = 1; rate_on = 1;
    feed(n, dmode);
    drain(n * (byp ? 1 : l1v) * l2v);
    mon_on = 0; rate_on = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    cfg_l1_code = 0; cfg_taps_code = 0; cfg_l2_code = 0; cfg_bypass = 0;
    run("R3", 4, 16, 2, 0, 20, 0, 0);
    run("R2", 0, 0, 1, 0, 8, 0, 0);
    run("R9", 1, 0, 2, 0, 5, 0, 0);
    run("R4", 2, 8, 1, 0, 4, 1, 1);
    run("R4", 2, 8, 1, 0, 4, 1, 2);
    run("R4", 1, 1, 1, 0, 6, 3, 3);
    run("R5", 2, 6, 3, 0, 10, 0, 0);
    run("R8", 3, 16, 0, 1, 5, 0, 0);

    // R7: illegal tap count, then correction.
    cfg_l1_code = 3; cfg_taps_code = 16; cfg_l2_code = 1; cfg_bypass = 0;
    do_reset();
    chk(cfg_err == 1'b1, "R7", cfg_err, 1);
    chk(in_ready == 1'b0, "R7", in_ready, 0);
    chk(out_data == 0, "R7", out_data, 0);
    load_coefs(0);
    l1v = 3; bv = 5; l2v = 1; byp_m = 0; rate_p = 8;
    exp_cnt = 0; strobe_cnt = 0; cur_tag = "R7"; mon_on = 1; rate_on = 1;
    in_valid = 1; in_data = 16'sd1234;
    repeat (40) @(negedge clk);
    chk(strobe_cnt == 0, "R7", strobe_cnt, 0);
    chk(in_ready == 1'b0, "R7", in_ready, 0);
    in_valid = 0;
    cfg_taps_code = 15;
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b0, "R7", cfg_err, 0);
    chk(in_ready == 1'b1, "R7", in_ready, 1);
    feed(4, 0);
    drain(4 * 3 * 1);
    mon_on = 0; rate_on = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule